// File: doc/BRIEF.md
# Bank-Switchable Dual-Port Memory

This block is a two-port synchronous memory built from a power-of-two number of equal banks (four by default). Each port has its own bank number, word address, write data, read data, byte-lane enables, a pair of chip enables, a write command and a mailbox-mode input. An external select bit per bank hands that whole bank to port 0 or to port 1. Since a bank belongs to exactly one port at any moment, the two ports never contend for storage and no arbitration exists between them. Flipping a select bit moves a bank, and the data in it, to the other side. A processor can fill a buffer that way and pass it to its peer without copying.

A port that reaches a bank it does not hold is blocked. Its write is dropped, its read returns zero, and a sticky per-port flag records the event until reset. When the mailbox-mode input is asserted, the cycle belongs to a mailbox area that lives outside this block, so the memory neither writes nor returns data. The word depth per bank is a parameter: the default of 64 words keeps elaboration small, and 16384 gives the full-size part.

Top module: `bank_switch_dpram`

## Requirements
- R1: While rstN is low, and after it rises, both read data outputs are zero and both violation flags are zero until an access changes them.
- R2: Bit b of bankSel selects the owner of bank b: 0 gives the bank to port 0, 1 gives it to port 1. A port addresses word pAddr of bank pBank.
- R3: A write takes effect at the clock edge when Ce0N is low, Ce1 is high, Mbox is low, Wr is high and the port owns the addressed bank. UpEn writes bits 15:8 and LoEn writes bits 7:0. A lane whose enable is low keeps its old contents.
- R4: A read (same conditions, Wr low) shows its data on RdData one cycle after the edge. A lane whose enable is low reads as zero.
- R5: If Ce0N is high or Ce1 is low, the port writes nothing and RdData is zero in the following cycle.
- R6: If Mbox is high, the memory ignores the port's cycle: nothing is written and RdData is zero in the following cycle.
- R7: An access to a bank the port does not own writes nothing, and RdData is zero in the following cycle.
- R8: The port's violation flag goes high the cycle after that port makes an access attempt (both chip enables active, Mbox low, at least one lane enabled) to a bank it does not own. The flag then stays high until reset. No other event sets it.
- R9: When both ports access the same bank and word in one cycle, only the owner's access takes effect.
- R10: Changing bankSel leaves the stored contents unchanged. The new owner reads the words the previous owner wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| bankSel | input | NUM_BANKS | Per-bank owner select, 0 = port 0, 1 = port 1 |
| p0Ce0N | input | 1 | Port 0 chip enable, active low |
| p0Ce1 | input | 1 | Port 0 chip enable, active high |
| p0Mbox | input | 1 | Port 0 mailbox mode; memory ignores the cycle |
| p0Wr | input | 1 | Port 0 write (1) or read (0) |
| p0UpEn | input | 1 | Port 0 upper lane enable (bits 15:8) |
| p0LoEn | input | 1 | Port 0 lower lane enable (bits 7:0) |
| p0Bank | input | log2(NUM_BANKS) | Port 0 bank number |
| p0Addr | input | ADDR_W | Port 0 word address within the bank |
| p0WrData | input | DATA_W | Port 0 write data |
| p0RdData | output | DATA_W | Port 0 read data, one cycle latency |
| p0Viol | output | 1 | Port 0 sticky ownership violation flag |
| p1Ce0N | input | 1 | Port 1 chip enable, active low |
| p1Ce1 | input | 1 | Port 1 chip enable, active high |
| p1Mbox | input | 1 | Port 1 mailbox mode; memory ignores the cycle |
| p1Wr | input | 1 | Port 1 write (1) or read (0) |
| p1UpEn | input | 1 | Port 1 upper lane enable (bits 15:8) |
| p1LoEn | input | 1 | Port 1 lower lane enable (bits 7:0) |
| p1Bank | input | log2(NUM_BANKS) | Port 1 bank number |
| p1Addr | input | ADDR_W | Port 1 word address within the bank |
| p1WrData | input | DATA_W | Port 1 write data |
| p1RdData | output | DATA_W | Port 1 read data, one cycle latency |
| p1Viol | output | 1 | Port 1 sticky ownership violation flag |

## Verification
A wrong ownership decode shows up in two ways. It corrupts words the bench later reads back through the owning port, and it makes the non-owner's read non-zero in the very next cycle. The bench therefore reads every word of every bank from both ports at once, under two different select patterns. A stuck or mis-set violation flag shows on the port one cycle after the offending access. Dropped or stray lane writes only surface on a later read of that word, so the lane, chip-enable and mailbox cases each write a known word and read it back right away.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
  localparam int NUM_PORTS = 2;

  // Per-port strobes handed from control to datapath
  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic rdHi;
    logic rdLo;
  } portStb_t;
endpackage

// File: rtl/bsdp_ctrl.sv
module bsdp_ctrl
  import bsdp_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_BANKS-1:0]             bankSel,
  input  logic [NUM_PORTS-1:0]             ce0N,
  input  logic [NUM_PORTS-1:0]             ce1,
  input  logic [NUM_PORTS-1:0]             mbox,
  input  logic [NUM_PORTS-1:0]             wr,
  input  logic [NUM_PORTS-1:0]             upEn,
  input  logic [NUM_PORTS-1:0]             loEn,
  input  logic [NUM_PORTS-1:0][BANK_W-1:0] bank,
  output portStb_t [NUM_PORTS-1:0]         stb,
  output logic [NUM_PORTS-1:0]             viol
);
  logic [NUM_PORTS-1:0] attempt;
  logic [NUM_PORTS-1:0] owned;
  logic [NUM_PORTS-1:0] go;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    // Both chip enables, memory mode, and at least one lane
    assign attempt[p] = !ce0N[p] && ce1[p] && !mbox[p] && (upEn[p] || loEn[p]);
    assign owned[p]   = (bankSel[bank[p]] == p[0]);
    assign go[p]      = attempt[p] && owned[p];

    assign stb[p].wrHi = go[p] &&  wr[p] && upEn[p];
    assign stb[p].wrLo = go[p] &&  wr[p] && loEn[p];
    assign stb[p].rdHi = go[p] && !wr[p] && upEn[p];
    assign stb[p].rdLo = go[p] && !wr[p] && loEn[p];

    always_ff @(posedge clk) begin
      if (!rstN)                        viol[p] <= 1'b0;
      else if (attempt[p] && !owned[p]) viol[p] <= 1'b1;
    end
  end
endmodule

// File: rtl/bsdp_datapath.sv
module bsdp_datapath
  import bsdp_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = BANK_W + ADDR_W,
  localparam int TOTAL    = NUM_BANKS << ADDR_W,
  localparam int LANE_W   = DATA_W / 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  portStb_t [NUM_PORTS-1:0]         stb,
  input  logic [NUM_PORTS-1:0][BANK_W-1:0] bank,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wrData,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [TOTAL];
  logic [NUM_PORTS-1:0][IDX_W-1:0] idx;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_idx
    assign idx[p] = {bank[p], addr[p]};
  end

  // Ownership is exclusive, so at most one port writes any word per cycle
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (stb[p].wrHi) mem[idx[p]][DATA_W-1:LANE_W] <= wrData[p][DATA_W-1:LANE_W];
      if (stb[p].wrLo) mem[idx[p]][LANE_W-1:0]      <= wrData[p][LANE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (!rstN) begin
        rdData[p] <= '0;
      end else begin
        rdData[p][DATA_W-1:LANE_W] <= stb[p].rdHi ? mem[idx[p]][DATA_W-1:LANE_W] : '0;
        rdData[p][LANE_W-1:0]      <= stb[p].rdLo ? mem[idx[p]][LANE_W-1:0]      : '0;
      end
    end
  end
endmodule

// File: rtl/bank_switch_dpram.sv
module bank_switch_dpram
  import bsdp_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankSel,
  input  logic                 p0Ce0N,
  input  logic                 p0Ce1,
  input  logic                 p0Mbox,
  input  logic                 p0Wr,
  input  logic                 p0UpEn,
  input  logic                 p0LoEn,
  input  logic [BANK_W-1:0]    p0Bank,
  input  logic [ADDR_W-1:0]    p0Addr,
  input  logic [DATA_W-1:0]    p0WrData,
  output logic [DATA_W-1:0]    p0RdData,
  output logic                 p0Viol,
  input  logic                 p1Ce0N,
  input  logic                 p1Ce1,
  input  logic                 p1Mbox,
  input  logic                 p1Wr,
  input  logic                 p1UpEn,
  input  logic                 p1LoEn,
  input  logic [BANK_W-1:0]    p1Bank,
  input  logic [ADDR_W-1:0]    p1Addr,
  input  logic [DATA_W-1:0]    p1WrData,
  output logic [DATA_W-1:0]    p1RdData,
  output logic                 p1Viol
);
  portStb_t [NUM_PORTS-1:0]         stb;
  logic [NUM_PORTS-1:0][BANK_W-1:0] bankV;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrV;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wdV;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdV;
  logic [NUM_PORTS-1:0]             violV;

  assign bankV = {p1Bank, p0Bank};
  assign addrV = {p1Addr, p0Addr};
  assign wdV   = {p1WrData, p0WrData};

  bsdp_ctrl #(.NUM_BANKS(NUM_BANKS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bankSel (bankSel),
    .ce0N    ({p1Ce0N, p0Ce0N}),
    .ce1     ({p1Ce1,  p0Ce1}),
    .mbox    ({p1Mbox, p0Mbox}),
    .wr      ({p1Wr,   p0Wr}),
    .upEn    ({p1UpEn, p0UpEn}),
    .loEn    ({p1LoEn, p0LoEn}),
    .bank    (bankV),
    .stb     (stb),
    .viol    (violV)
  );

  bsdp_datapath #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .bank   (bankV),
    .addr   (addrV),
    .wrData (wdV),
    .rdData (rdV)
  );

  assign p0RdData = rdV[0];
  assign p1RdData = rdV[1];
  assign p0Viol   = violV[0];
  assign p1Viol   = violV[1];
endmodule

// File: rtl/bank_switch_dpram_chk.sv
module bank_switch_dpram_chk #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int LANE_W   = DATA_W / 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_BANKS-1:0] bankSel,
  input logic                 p0Ce0N,
  input logic                 p0Ce1,
  input logic                 p0Mbox,
  input logic                 p0Wr,
  input logic                 p0UpEn,
  input logic                 p0LoEn,
  input logic [BANK_W-1:0]    p0Bank,
  input logic [DATA_W-1:0]    p0RdData,
  input logic                 p0Viol,
  input logic                 p1Ce0N,
  input logic                 p1Ce1,
  input logic                 p1Mbox,
  input logic                 p1Wr,
  input logic                 p1UpEn,
  input logic                 p1LoEn,
  input logic [BANK_W-1:0]    p1Bank,
  input logic [DATA_W-1:0]    p1RdData,
  input logic                 p1Viol
);
  logic p0Try, p1Try, p0Own, p1Own;
  assign p0Try = !p0Ce0N && p0Ce1 && !p0Mbox && (p0UpEn || p0LoEn);
  assign p1Try = !p1Ce0N && p1Ce1 && !p1Mbox && (p1UpEn || p1LoEn);
  assign p0Own = !bankSel[p0Bank];
  assign p1Own =  bankSel[p1Bank];

  assert_p0_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    p0Viol |=> p0Viol);
  assert_p1_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    p1Viol |=> p1Viol);
  assert_p0_viol_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(p0Viol) |-> $past(p0Try && !p0Own));
  assert_p1_viol_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(p1Viol) |-> $past(p1Try && !p1Own));
  assert_p0_ce_off_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (p0Ce0N || !p0Ce1) |=> (p0RdData == '0));
  assert_p1_ce_off_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (p1Ce0N || !p1Ce1) |=> (p1RdData == '0));
  assert_p0_mbox_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    p0Mbox |=> (p0RdData == '0));
  assert_p1_mbox_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    p1Mbox |=> (p1RdData == '0));
  assert_p0_foreign_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !p0Own |=> (p0RdData == '0));
  assert_p1_foreign_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !p1Own |=> (p1RdData == '0));
  assert_p0_lane_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !p0UpEn |=> (p0RdData[DATA_W-1:LANE_W] == '0));
  assert_p1_lane_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !p1LoEn |=> (p1RdData[LANE_W-1:0] == '0));
endmodule

bind bank_switch_dpram bank_switch_dpram_chk #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .bankSel(bankSel),
  .p0Ce0N(p0Ce0N), .p0Ce1(p0Ce1), .p0Mbox(p0Mbox), .p0Wr(p0Wr),
  .p0UpEn(p0UpEn), .p0LoEn(p0LoEn), .p0Bank(p0Bank), .p0RdData(p0RdData), .p0Viol(p0Viol),
  .p1Ce0N(p1Ce0N), .p1Ce1(p1Ce1), .p1Mbox(p1Mbox), .p1Wr(p1Wr),
  .p1UpEn(p1UpEn), .p1LoEn(p1LoEn), .p1Bank(p1Bank), .p1RdData(p1RdData), .p1Viol(p1Viol)
);

// File: tb/test_bank_switch_dpram.sv
module test_bank_switch_dpram;
  localparam int NB = 4;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rstN;
  logic [NB-1:0] bankSel;
  logic p0Ce0N, p0Ce1, p0Mbox, p0Wr, p0UpEn, p0LoEn;
  logic [1:0] p0Bank;
  logic [AW-1:0] p0Addr;
  logic [DW-1:0] p0WrData, p0RdData;
  logic p0Viol;
  logic p1Ce0N, p1Ce1, p1Mbox, p1Wr, p1UpEn, p1LoEn;
  logic [1:0] p1Bank;
  logic [AW-1:0] p1Addr;
  logic [DW-1:0] p1WrData, p1RdData;
  logic p1Viol;

  int vecs = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_switch_dpram #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) i_bank_switch_dpram (.*);

  function automatic logic [DW-1:0] patA(int b, int a);
    return 16'(b * 16'h3001 + a * 16'h0107 + 16'h0A5C);
  endfunction
  function automatic logic [DW-1:0] patB(int b, int a);
    return 16'(b * 16'h1203 + a * 16'h0311) ^ 16'hB00B;
  endfunction
  function automatic logic [DW-1:0] patC(int b, int a);
    return 16'(b * 16'h0451 + a * 16'h2105) ^ 16'h6E71;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one port: ce0N, ce1, mbox, wr, up, lo, bank, addr, data
  task automatic setP(int p, logic c0n, logic c1, logic mb, logic w, logic u, logic l,
                      int b, int a, logic [DW-1:0] d);
    if (p == 0) begin
      p0Ce0N = c0n; p0Ce1 = c1; p0Mbox = mb; p0Wr = w; p0UpEn = u; p0LoEn = l;
      p0Bank = 2'(b); p0Addr = AW'(a); p0WrData = d;
    end else begin
      p1Ce0N = c0n; p1Ce1 = c1; p1Mbox = mb; p1Wr = w; p1UpEn = u; p1LoEn = l;
      p1Bank = 2'(b); p1Addr = AW'(a); p1WrData = d;
    end
  endtask

  task automatic idle();
    setP(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, '0);
    setP(1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, '0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    idle();
    bankSel = '0;
    rstN = 1'b0;
    repeat (3) step();
    // R1: reset state
    chk("R1 p0 read data after reset", p0RdData, '0);
    chk("R1 p1 read data after reset", p1RdData, '0);
    chk("R1 p0 viol after reset", {15'b0, p0Viol}, 16'h0);
    rstN = 1'b1;
    step();
    chk("R1 p1 viol after reset", {15'b0, p1Viol}, 16'h0);

    // R2/R3: all banks owned by port 0, fill with patA
    bankSel = 4'b0000;
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < WORDS; a++) begin
        setP(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, b, a, patA(b, a));
        step();
      end
    idle();
    step();
    chk("R8 p0 no viol on owned writes", {15'b0, p0Viol}, 16'h0);
    chk("R8 p1 no viol while idle", {15'b0, p1Viol}, 16'h0);

    // R10/R2/R7: hand every bank to port 1, both ports read every word
    bankSel = 4'b1111;
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < WORDS; a++) begin
        setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, b, a, '0);
        setP(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, b, a, '0);
        step();
        chk("R10 new owner reads old data", p1RdData, patA(b, a));
        chk("R7 non-owner read is zero", p0RdData, '0);
      end
    idle();
    step();
    chk("R8 p0 viol set by foreign read", {15'b0, p0Viol}, 16'h1);
    chk("R8 p1 viol clear", {15'b0, p1Viol}, 16'h0);

    // R9: mixed ownership, both ports write the same word each cycle
    bankSel = 4'b1010;
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < WORDS; a++) begin
        setP(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, b, a, patB(b, a));
        setP(1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, b, a, patC(b, a));
        step();
      end
    idle();
    step();
    chk("R8 p1 viol set by foreign write", {15'b0, p1Viol}, 16'h1);
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < WORDS; a++) begin
        setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, b, a, '0);
        setP(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, b, a, '0);
        step();
        if (b % 2 == 0) begin
          chk("R9 owner p0 write kept", p0RdData, patB(b, a));
          chk("R7 p1 foreign read zero", p1RdData, '0);
        end else begin
          chk("R9 owner p1 write kept", p1RdData, patC(b, a));
          chk("R7 p0 foreign read zero", p0RdData, '0);
        end
      end
    idle();
    repeat (3) step();
    chk("R8 p0 viol stays high", {15'b0, p0Viol}, 16'h1);
    chk("R8 p1 viol stays high", {15'b0, p1Viol}, 16'h1);

    // R3/R4: byte lanes on bank 0 word 5 (port 0 owner)
    bankSel = 4'b0000;
    setP(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0, 5, 16'hC3E7);
    step();
    setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 5, '0);
    step();
    chk("R3 upper lane only write", p0RdData, {8'hC3, patB(0, 5)[7:0]});
    setP(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 5, 16'h9D42);
    step();
    setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 5, '0);
    step();
    chk("R3 lower lane only write", p0RdData, 16'hC342);
    setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 5, '0);
    step();
    chk("R4 upper lane disabled reads zero", p0RdData, 16'h0042);
    setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0, 5, '0);
    step();
    chk("R4 lower lane disabled reads zero", p0RdData, 16'hC300);

    // R5: chip enables inactive
    setP(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 0, 6, 16'hFFFF);
    step();
    setP(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 0, 7, 16'hFFFF);
    step();
    setP(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 6, '0);
    step();
    chk("R5 read with Ce1 low is zero", p0RdData, '0);
    setP(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 6, '0);
    step();
    chk("R5 read with Ce0N high is zero", p0RdData, '0);
    setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 6, '0);
    step();
    chk("R5 write with Ce0N high dropped", p0RdData, patB(0, 6));
    setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 7, '0);
    step();
    chk("R5 write with Ce1 low dropped", p0RdData, patB(0, 7));

    // R6: mailbox cycles ignored by the memory
    setP(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 8, 16'h0000);
    step();
    setP(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 8, '0);
    step();
    chk("R6 mailbox read is zero", p0RdData, '0);
    setP(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 8, '0);
    step();
    chk("R6 mailbox write dropped", p0RdData, patB(0, 8));

    // R1: reset clears flags and read data
    idle();
    rstN = 1'b0;
    step();
    chk("R1 p0 viol cleared by reset", {15'b0, p0Viol}, 16'h0);
    chk("R1 p1 viol cleared by reset", {15'b0, p1Viol}, 16'h0);
    chk("R1 p0 read data cleared by reset", p0RdData, '0);
    rstN = 1'b1;
    step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule